// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between an on-chip request port and an external 32K x 8 asynchronous static RAM. It accepts one read or write per request and turns it into a timed sequence of active-low select, write-enable and output-enable strobes. While a transaction runs, it holds the address pins steady. It also controls the direction of the shared data bus. The RAM has no clock, so every minimum or maximum time it requires is converted into a whole number of system clock cycles. This conversion uses the nanosecond parameters and the clock period, and always rounds up.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is in standby. A request transfers on the cycle where `req_valid` and `req_ready` are both high, and the address, direction and write data are sampled on that cycle. A requester that sees `req_ready` low must keep `req_valid` and its payload unchanged until the transfer happens. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse carrying `rsp_rdata`, and it is produced only for reads.

Between transactions the strobes return to standby and the data driver is switched off. A write asserts its data only while write enable is low, plus the one cycle after write enable rises. Output enable stays high for the whole of a write, so the bus never has two drivers.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both 1, with `req_write`=1 meaning write. Each transfer produces exactly one falling edge of `mem_cs_n`. While the sequencer is busy, `req_ready` is 0 and a held `req_valid` starts nothing.
- R3: In a write, `mem_cs_n` is low for at least 1 cycle before `mem_we_n` falls. `mem_we_n` is low only while `mem_cs_n` is low, for exactly WP cycles (6 at the default 10 ns clock). `mem_addr` does not change while `mem_cs_n` is low.
- R4: `mem_oe_n` stays 1 throughout a write. `mem_dq_oe` is 1 only while `mem_we_n` is low and in the single cycle after it rises, and never while `mem_oe_n` is 0.
- R5: In a read, `mem_cs_n` and `mem_oe_n` are low with `mem_we_n` high for exactly RA cycles (7 at default). `mem_dq_in` is sampled at the clock edge that ends this window. `rsp_valid` is high for one cycle right after that edge, RA cycles after the transfer edge, with `rsp_rdata` set to the sampled byte.
- R6: Two transfers are separated by at least the minimum cycle time, which is 7 clock edges at default for both reads and writes.
- R7: After `mem_oe_n` rises at the end of a read, `mem_dq_oe` does not rise for at least RG cycles (3 at default), which covers the RAM's bus release time.
- R8: A byte written to any address, including 0x0000 and 0x7FFF, reads back unchanged when writes and reads are issued back to back with `req_valid` held high.
- R9: `rsp_valid` is pulsed for every read, in the cycle where `mem_oe_n` rises, and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse, read data valid |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Address pins to the RAM |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_in | input | 8 | Data from the RAM |
| mem_dq_oe | output | 1 | Enable of the data pad driver |

## Verification
The following pin-level timing rules are checked by assertions on every cycle:
- the strobe-overlap and standby rules;
- the exact write-enable and read window lengths;
- the spacing between transfers;
- the turnaround between releasing output enable and turning the driver on;
- the pairing of `rsp_valid` with the end of each read window.

Other properties can only be shown by the bench's scenarios, using a memory model whose data is wrong until the access time has passed:
- the write data actually lands at the right address;
- reads capture valid data rather than early garbage;
- back-to-back traffic loses no byte;
- a held request during a busy period starts no extra memory cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC,
    ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  // ceiling division of a nanosecond limit by the clock period
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t strobe_of(seq_state_e s);
    strobe_t r;
    r = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
    case (s)
      ST_WSET: r.cs_n = 1'b0;
      ST_WPUL: begin r.cs_n = 1'b0; r.we_n = 1'b0; r.drv = 1'b1; end
      ST_WHLD: begin r.cs_n = 1'b0; r.drv = 1'b1; end
      ST_RACC: begin r.cs_n = 1'b0; r.oe_n = 1'b0; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_tcount.sv
module sram_tcount #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WP_CYC    = 6,
  parameter int unsigned WGAP_CYC  = 0,
  parameter int unsigned RA_CYC    = 7,
  parameter int unsigned RGAP_CYC  = 3,
  parameter int unsigned CNT_W     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic fire,
  output logic capture,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic drv
);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WP    = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RA    = CNT_W'(RA_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RGAP  = CNT_W'(RGAP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WGAP  = CNT_W'((WGAP_CYC > 0) ? WGAP_CYC - 1 : 0);
  localparam bit               HAS_WGAP = (WGAP_CYC > 0);

  seq_state_e       state_q, state_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             cnt_zero;
  strobe_t          pins_q;

  sram_tcount #(.CNT_W(CNT_W)) tcnt_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (cnt_zero)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign fire      = req_valid && req_ready;
  assign capture   = (state_q == ST_RACC) && cnt_zero;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    case (state_q)
      ST_IDLE: if (fire) begin
        ld = 1'b1;
        if (req_write) begin state_d = ST_WSET; ld_val = LD_SETUP; end
        else           begin state_d = ST_RACC; ld_val = LD_RA;    end
      end
      ST_WSET: if (cnt_zero) begin
        state_d = ST_WPUL; ld = 1'b1; ld_val = LD_WP;
      end
      ST_WPUL: if (cnt_zero) state_d = ST_WHLD;
      ST_WHLD: begin
        if (HAS_WGAP) begin state_d = ST_GAP; ld = 1'b1; ld_val = LD_WGAP; end
        else          state_d = ST_IDLE;
      end
      ST_RACC: if (cnt_zero) begin
        state_d = ST_GAP; ld = 1'b1; ld_val = LD_RGAP;
      end
      ST_GAP:  if (cnt_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes are flops fed from the next-state decode: glitch-free pins
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pins_q  <= strobe_of(ST_IDLE);
    end else begin
      state_q <= state_d;
      pins_q  <= strobe_of(state_d);
    end
  end

  assign cs_n = pins_q.cs_n;
  assign we_n = pins_q.we_n;
  assign oe_n = pins_q.oe_n;
  assign drv  = pins_q.drv;
endmodule

// File: rtl/sram_dpath.sv
module sram_dpath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      rsp_valid <= capture;
      if (fire) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned T_WC_NS    = 70,
  parameter int unsigned T_WP_NS    = 50,
  parameter int unsigned T_DS_NS    = 30,
  parameter int unsigned T_AW_NS    = 65,
  parameter int unsigned T_RC_NS    = 70,
  parameter int unsigned T_AA_NS    = 70,
  parameter int unsigned T_OEA_NS   = 35,
  parameter int unsigned T_REL_NS   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int unsigned SETUP_EFF = umax(SETUP_CYC, 1);
  localparam int unsigned AW_CYC    = ns2cyc(T_AW_NS, CLK_NS);
  localparam int unsigned WP_CYC    = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS)),
                                           umax((AW_CYC > SETUP_EFF) ? AW_CYC - SETUP_EFF : 1, 1));
  localparam int unsigned WC_CYC    = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned W_USED    = SETUP_EFF + WP_CYC + 2;
  localparam int unsigned WGAP_CYC  = (WC_CYC > W_USED) ? WC_CYC - W_USED : 0;
  localparam int unsigned RA_CYC    = umax(umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OEA_NS, CLK_NS)), 1);
  localparam int unsigned RC_CYC    = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned RGAP_CYC  = umax(umax(ns2cyc(T_REL_NS, CLK_NS),
                                           (RC_CYC > RA_CYC + 1) ? RC_CYC - RA_CYC - 1 : 0), 1);
  localparam int unsigned MAX_LD    = umax(umax(WP_CYC, RA_CYC), umax(umax(RGAP_CYC, WGAP_CYC), SETUP_EFF));
  localparam int unsigned CNT_W     = $clog2(MAX_LD + 1);

  logic fire, capture;

  sram_seq_fsm #(
    .SETUP_CYC (SETUP_EFF),
    .WP_CYC    (WP_CYC),
    .WGAP_CYC  (WGAP_CYC),
    .RA_CYC    (RA_CYC),
    .RGAP_CYC  (RGAP_CYC),
    .CNT_W     (CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .fire      (fire),
    .capture   (capture),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .drv       (mem_dq_oe)
  );

  sram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned WP_CYC   = 6,
  parameter int unsigned RA_CYC   = 7,
  parameter int unsigned WC_CYC   = 7,
  parameter int unsigned RC_CYC   = 7,
  parameter int unsigned RGAP_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic              rsp_valid
);
  logic        fire;
  logic [15:0] we_lo, oe_lo, since_fire, oe_hi;
  logic        last_wr;

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo      <= '0;
      oe_lo      <= '0;
      since_fire <= 16'hFFFF;
      oe_hi      <= 16'hFFFF;
      last_wr    <= 1'b0;
    end else begin
      we_lo <= mem_we_n ? 16'd0 : we_lo + 16'd1;
      oe_lo <= mem_oe_n ? 16'd0 : oe_lo + 16'd1;
      if (fire) begin
        since_fire <= 16'd1;
        last_wr    <= req_write;
      end else if (since_fire != 16'hFFFF) since_fire <= since_fire + 16'd1;
      if (!mem_oe_n) oe_hi <= 16'd0;
      else if (oe_hi != 16'hFFFF) oe_hi <= oe_hi + 16'd1;
    end
  end

  assert_standby_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_we_inside_cs_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n);

  assert_cs_leads_we_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> !$past(mem_cs_n));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  assert_we_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo == 16'(WP_CYC)));

  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  assert_drv_window_R4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && (!mem_we_n || $rose(mem_we_n))));

  assert_read_window_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_lo == 16'(RA_CYC)));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_cycle_time_R6: assert property (@(posedge clk) disable iff (rst)
    fire |-> (since_fire >= (last_wr ? 16'(WC_CYC) : 16'(RC_CYC))));

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_hi >= 16'(RGAP_CYC)));

  assert_rsp_pairs_read_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $rose(mem_oe_n));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .WP_CYC   (WP_CYC),
  .RA_CYC   (RA_CYC),
  .WC_CYC   (WC_CYC),
  .RC_CYC   (RC_CYC),
  .RGAP_CYC (RGAP_CYC)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .rsp_valid (rsp_valid)
);

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;
  localparam int WP = 6, RA = 7, RG = 3, TWC = 7;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int checks = 0, errors = 0, cyc = 0;

  sram_strobe_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural RAM and pin monitor, evaluated mid-cycle
  logic [7:0] ram [int unsigned];
  logic prev_we = 1, prev_cs = 1, prev_oe = 1, prev_drv = 0;
  int we_cnt = 0, we_width = -1, cs_lead = 0, cs_lo = 0, rd_cnt = 0, oe_hi = 1000;
  int cs_falls = 0, rsp_cnt = 0, oe_in_write = 0, drv_bad = 0, min_turn = 1000;
  int last_rsp_cyc = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !mem_cs_n) cs_falls++;
      if (prev_we && !mem_we_n) cs_lead = cs_lo;
      if (!mem_we_n && !mem_oe_n) oe_in_write++;
      if (mem_dq_oe && !(!mem_we_n || !prev_we) ) drv_bad++;
      if (mem_dq_oe && !mem_oe_n) drv_bad++;
      if (!prev_drv && mem_dq_oe && oe_hi < min_turn) min_turn = oe_hi;
      if (!prev_we && mem_we_n && !mem_cs_n) begin
        we_width = we_cnt;
        if (mem_dq_oe) ram[int'(mem_addr)] = mem_dq_out;
      end
      if (rsp_valid) begin rsp_cnt++; last_rsp_cyc = cyc; end
    end
    we_cnt  = mem_we_n ? 0 : we_cnt + 1;
    cs_lo   = mem_cs_n ? 0 : cs_lo + 1;
    oe_hi   = mem_oe_n ? oe_hi + 1 : 0;
    rd_cnt  = (!mem_cs_n && !mem_oe_n && mem_we_n) ? rd_cnt + 1 : 0;
    if (rd_cnt >= RA && ram.exists(int'(mem_addr))) mem_dq_in = ram[int'(mem_addr)];
    else if (rd_cnt >= RA) mem_dq_in = 8'h00;
    else mem_dq_in = ram.exists(int'(mem_addr)) ? ~ram[int'(mem_addr)] : 8'hFF;
    prev_we = mem_we_n; prev_cs = mem_cs_n; prev_oe = mem_oe_n; prev_drv = mem_dq_oe;
  end

  // issue one request; returns transfer edge number; leaves valid high if keep
  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d,
                       input bit keep, output int fire_edge);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    fire_edge = cyc + 1;
    @(negedge clk);
    if (!keep) req_valid = 0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
        "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d);
    int fe;
    issue(1, a, d, 0, fe);
    wait_idle();
    chk(we_width == WP, "R3 write enable width", we_width, WP);
    chk(cs_lead >= 1, "R3 select leads write enable", cs_lead, 1);
    chk(oe_in_write == 0 && drv_bad == 0, "R4 driver/oe window", oe_in_write + drv_bad, 0);
    chk(ram.exists(int'(a)) && ram[int'(a)] == d, "R8 byte stored",
        ram.exists(int'(a)) ? int'(ram[int'(a)]) : -1, d);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 standby after write",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
  endtask

  task automatic t_read(input logic [14:0] a, input logic [7:0] exp);
    int fe, n0;
    n0 = rsp_cnt;
    issue(0, a, 8'h00, 0, fe);
    while (!rsp_valid) @(negedge clk);
    chk(cyc - fe == RA, "R5 response latency", cyc - fe, RA);
    chk(rsp_rdata == exp, "R5 read data", rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid && rsp_cnt == n0 + 1, "R5 single pulse", rsp_cnt - n0, 1);
    wait_idle();
  endtask

  task automatic t_no_rsp_on_write();
    int n0, fe;
    n0 = rsp_cnt;
    issue(1, 15'h0123, 8'h3C, 0, fe);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(rsp_cnt == n0, "R9 no response for write", rsp_cnt - n0, 0);
  endtask

  task automatic t_back_to_back();
    int fe [8];
    logic [14:0] ad [4] = '{15'h0000, 15'h7FFF, 15'h2AAA, 15'h5555};
    logic [7:0]  dv [4] = '{8'hFF, 8'h00, 8'hAA, 8'h55};
    int cs0, n0;
    cs0 = cs_falls; n0 = rsp_cnt;
    for (int i = 0; i < 4; i++) issue(1, ad[i], dv[i], 1, fe[i]);
    for (int i = 0; i < 4; i++) begin
      issue(0, ad[i], 8'h00, 1, fe[4+i]);
      while (!rsp_valid) @(negedge clk);
      chk(rsp_rdata == dv[i], "R8 back-to-back readback", rsp_rdata, dv[i]);
    end
    req_valid = 0;
    wait_idle();
    for (int i = 1; i < 8; i++)
      chk(fe[i] - fe[i-1] >= TWC, "R6 transfer spacing", fe[i] - fe[i-1], TWC);
    chk(cs_falls - cs0 == 8, "R2 one memory cycle per transfer", cs_falls - cs0, 8);
    chk(rsp_cnt - n0 == 4, "R9 one response per read", rsp_cnt - n0, 4);
  endtask

  task automatic t_turnaround();
    int fe;
    min_turn = 1000;
    issue(0, 15'h0000, 8'h00, 1, fe);
    issue(1, 15'h0040, 8'h96, 0, fe);
    wait_idle();
    chk(min_turn >= RG, "R7 read-to-write bus turnaround", min_turn, RG);
    t_read(15'h0040, 8'h96);
  endtask

  initial begin
    #200_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write(15'h0010, 8'hA5);
    t_read(15'h0010, 8'hA5);
    t_write(15'h7FFF, 8'h5A);
    t_read(15'h7FFF, 8'h5A);
    t_no_rsp_on_write();
    t_back_to_back();
    t_turnaround();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule